// File: doc/BRIEF.md
# UART Receiver with Buffered Status

This block is the receive half of an asynchronous serial port. The serial input passes through a two-flop synchronizer. A bit-recovery state machine samples it at mid-bit, using an externally supplied sample tick at sixteen times the bit rate. Recovered bits collect in a shift register. Each completed frame is pushed into a small receive buffer: an array of `DEPTH` entries, two by default. Every entry holds the data byte together with that frame's own framing-error and parity-error flags, so the status seen by software always belongs to the byte it is about to read.

Software watches `rxComplete` or the interrupt. It samples the status outputs, which describe the oldest unread entry, and then pulses `dataRead` to take that entry's byte and pop it. If both entries are occupied and another frame completes, that frame is discarded and an overrun flag is raised. Dropping the enable bit stops reception immediately and discards everything buffered.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, and whenever the buffer is empty, `rxComplete` is 0. It is 1 while at least one unread entry is buffered. It returns to 0 once reads have emptied the buffer.
- R2: While `rxEnable` is 0, the block accepts no frames. Driving `rxEnable` low discards all buffered entries and clears the overrun flag, so `rxComplete` and `overrun` are 0 from the next clock.
- R3: `irq` is 1 exactly when `rxComplete` is 1 and `irqEnable` is 1.
- R4: The buffer holds two frames in arrival order. `rxData`, `frameErr` and `parityErr` show the oldest unread entry. A `dataRead` pulse pops that entry, and the next entry's byte and flags then appear.
- R5: `frameErr` of an entry is 1 when its stop bit was sampled as 0, and 0 when it was sampled as 1.
- R6: If a frame completes while both entries are full and no read occurs in that cycle, `overrun` becomes 1 and the frame is lost. While `overrun` is 1, further completed frames are lost as well.
- R7: A `dataRead` pulse while the buffer is not empty clears `overrun` at the next clock.
- R8: With `parityEnable`=1, a parity bit follows the data. `parityOdd`=1 expects an odd count of ones across the data and parity bits, and `parityOdd`=0 expects an even count. A mismatch sets that entry's `parityErr`. With `parityEnable`=0 there is no parity bit and `parityErr` reads 0.
- R9: A falling edge starts a frame only if the line is still low at the mid-bit sample, 8 ticks later. A shorter low pulse produces no entry.
- R10: A frame is one start bit (0), 8 data bits sent LSB first, an optional parity bit and one stop bit (1). After a framing error, the receiver waits for the line to go high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idles high |
| rxEnable | input | 1 | Receiver enable; 0 stops reception and flushes the buffer |
| parityEnable | input | 1 | 1: a parity bit follows the data bits |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| irqEnable | input | 1 | Reception-complete interrupt enable |
| dataRead | input | 1 | One-cycle pulse: consume and pop the oldest entry |
| rxData | output | 8 | Data byte of the oldest entry |
| frameErr | output | 1 | Framing-error flag of the oldest entry |
| parityErr | output | 1 | Parity-error flag of the oldest entry |
| overrun | output | 1 | A frame was lost because the buffer was full |
| rxComplete | output | 1 | Buffer holds at least one unread entry |
| irq | output | 1 | Reception-complete interrupt |

## Verification
The bench sweeps all 256 byte values without parity, and a spread of bytes under both parity senses with correct and deliberately wrong parity bits. A bit-order or parity-sense mistake therefore shows as a wrong byte or a false or missing `parityErr`. It lets two frames with different error flags queue up and checks that the flags change with the pop. A design that kept the flags in one shared register would show the second frame's flags against the first byte. A third frame sent into a full buffer must be lost and raise `overrun`, while the two older bytes still come out intact. A design that overwrote an entry, or never cleared the flag on read, fails here. Glitch starts, a zero stop bit followed by recovery, and disabling with data queued catch receivers that lock onto noise, miss the line returning high, or keep stale bytes across a disable.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // strobes from bit-recovery control to the datapath
  typedef struct packed {
    logic shiftEn;   // capture bitVal as next data bit
    logic parEn;     // capture bitVal as received parity bit
    logic frameDone; // bitVal is the stop bit, frame complete
    logic bitVal;    // sampled line value
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxLine,
  input  logic      rxEnable,
  input  logic      parityEnable,
  output rxStrobe_t strobe
);
  localparam int TW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_BITS);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {IDLE, START, DATA, PARITY, STOP, WAITHIGH} rxState_t;

  rxState_t state;
  logic [1:0] syncQ;
  logic rxS;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitIdx;
  logic atEnd;

  assign rxS   = syncQ[1];
  assign atEnd = (tickCnt == TW'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      strobe  <= '0;
    end else begin
      strobe <= '0;
      strobe.bitVal <= rxS;
      if (!rxEnable) begin
        state   <= IDLE;
        tickCnt <= '0;
        bitIdx  <= '0;
      end else if (sampleTick) begin
        unique case (state)
          IDLE: begin
            tickCnt <= '0;
            if (!rxS) state <= START;
          end
          START: begin
            if (tickCnt == TW'(HALF - 1)) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= rxS ? IDLE : DATA;
            end else tickCnt <= tickCnt + 1'b1;
          end
          DATA: begin
            tickCnt <= tickCnt + 1'b1;
            if (atEnd) begin
              strobe.shiftEn <= 1'b1;
              if (bitIdx == BW'(DATA_BITS - 1)) begin
                bitIdx <= '0;
                state  <= parityEnable ? PARITY : STOP;
              end else bitIdx <= bitIdx + 1'b1;
            end
          end
          PARITY: begin
            tickCnt <= tickCnt + 1'b1;
            if (atEnd) begin
              strobe.parEn <= 1'b1;
              state <= STOP;
            end
          end
          STOP: begin
            tickCnt <= tickCnt + 1'b1;
            if (atEnd) begin
              strobe.frameDone <= 1'b1;
              state <= rxS ? IDLE : WAITHIGH;
            end
          end
          WAITHIGH: if (rxS) state <= IDLE;
          default: state <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_data.sv
module uart_rx_data
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 rxEnable,
  input  logic                 parityEnable,
  input  logic                 parityOdd,
  input  logic                 dataRead,
  output logic [DATA_BITS-1:0] headData,
  output logic                 headFe,
  output logic                 headPe,
  output logic                 notEmpty,
  output logic                 overrunQ
);
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [DATA_BITS-1:0] data;
    logic fe;
    logic pe;
  } entry_t;

  logic [DATA_BITS-1:0] shiftReg;
  logic parRecv;
  entry_t entries [DEPTH];
  entry_t newEntry;
  logic [CW-1:0] count, wrIdx;
  logic pop, push, full, setOvr;

  assign full   = (count == CW'(DEPTH));
  assign pop    = dataRead && (count != '0);
  assign push   = strobe.frameDone && !overrunQ && (!full || pop);
  assign setOvr = strobe.frameDone && full && !pop;
  assign wrIdx  = count - CW'(pop);

  assign newEntry.data = shiftReg;
  assign newEntry.fe   = !strobe.bitVal;
  assign newEntry.pe   = parityEnable && ((^shiftReg ^ parRecv) != parityOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parRecv  <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {strobe.bitVal, shiftReg[DATA_BITS-1:1]};
      if (strobe.parEn)   parRecv  <= strobe.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      overrunQ <= 1'b0;
      for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
    end else if (!rxEnable) begin
      count    <= '0;
      overrunQ <= 1'b0;
    end else begin
      if (pop)
        for (int i = 0; i < DEPTH - 1; i++) entries[i] <= entries[i+1];
      for (int i = 0; i < DEPTH; i++)
        if (push && wrIdx == CW'(i)) entries[i] <= newEntry;
      count <= count - CW'(pop) + CW'(push);
      if (pop)         overrunQ <= 1'b0;
      else if (setOvr) overrunQ <= 1'b1;
    end
  end

  assign headData = entries[0].data;
  assign headFe   = entries[0].fe;
  assign headPe   = entries[0].pe;
  assign notEmpty = (count != '0);
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 rxEnable,
  input  logic                 parityEnable,
  input  logic                 parityOdd,
  input  logic                 irqEnable,
  input  logic                 dataRead,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 frameErr,
  output logic                 parityErr,
  output logic                 overrun,
  output logic                 rxComplete,
  output logic                 irq
);
  rxStrobe_t strobe;

  uart_rx_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .parityEnable(parityEnable), .strobe(strobe)
  );

  uart_rx_data #(.DATA_BITS(DATA_BITS), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxEnable(rxEnable),
    .parityEnable(parityEnable), .parityOdd(parityOdd), .dataRead(dataRead),
    .headData(rxData), .headFe(frameErr), .headPe(parityErr),
    .notEmpty(rxComplete), .overrunQ(overrun)
  );

  assign irq = rxComplete && irqEnable;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic parityEnable,
  input logic irqEnable,
  input logic dataRead,
  input logic parityErr,
  input logic overrun,
  input logic rxComplete,
  input logic irq
);
  // R2
  flush_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxComplete && !overrun));
  // R3
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rxComplete);
  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq);
  // R6
  overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> rxComplete);
  // R7
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && dataRead && rxComplete) |=> !overrun);
  // R8
  parity_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxComplete) && !parityEnable && $stable(parityEnable)) |-> !parityErr);
endmodule

bind uart_rx_buf uart_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .parityEnable(parityEnable),
  .irqEnable(irqEnable), .dataRead(dataRead), .parityErr(parityErr),
  .overrun(overrun), .rxComplete(rxComplete), .irq(irq)
);

// File: tb/uart_rx_buf_tb.sv
module uart_rx_buf_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b1;
  logic rxLine = 1'b1;
  logic rxEnable = 1'b1;
  logic parityEnable = 1'b0;
  logic parityOdd = 1'b0;
  logic irqEnable = 1'b1;
  logic dataRead = 1'b0;
  logic [7:0] rxData;
  logic frameErr, parityErr, overrun, rxComplete, irq;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  uart_rx_buf u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .parityEnable(parityEnable), .parityOdd(parityOdd),
    .irqEnable(irqEnable), .dataRead(dataRead), .rxData(rxData),
    .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun),
    .rxComplete(rxComplete), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bitOut(input logic b);
    rxLine = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit withPar, input bit parBit, input bit stopBit);
    bitOut(1'b0);
    for (int i = 0; i < 8; i++) bitOut(d[i]);
    if (withPar) bitOut(parBit);
    bitOut(stopBit);
    rxLine = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic readPop();
    dataRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int errs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset rxComplete", rxComplete, 0);
    chk("R3 reset irq", irq, 0);
    chk("R6 reset overrun", overrun, 0);

    // R10 R1 R5: exhaustive byte sweep without parity
    errs = 0;
    for (int v = 0; v < 256; v++) begin
      sendFrame(v[7:0], 0, 0, 1);
      if (rxComplete !== 1'b1 || rxData !== v[7:0] || frameErr !== 1'b0 || parityErr !== 1'b0) errs++;
      readPop();
      if (rxComplete !== 1'b0) errs++;
    end
    chk("R10 R1 byte sweep mismatches", errs, 0);

    // R8: both parity senses, correct and wrong parity bit
    parityEnable = 1'b1;
    for (int odd = 0; odd < 2; odd++) begin
      parityOdd = odd[0];
      errs = 0;
      for (int k = 0; k < 32; k++) begin
        logic [7:0] d;
        logic good;
        d = 8'(k * 37 + 11);
        good = (^d) ^ odd[0];
        for (int bad = 0; bad < 2; bad++) begin
          sendFrame(d, 1, good ^ bad[0], 1);
          if (rxData !== d || parityErr !== bad[0] || frameErr !== 1'b0) errs++;
          readPop();
        end
      end
      chk(odd ? "R8 odd parity sweep" : "R8 even parity sweep", errs, 0);
    end

    // R4: flags travel with their entry
    parityOdd = 1'b0;
    sendFrame(8'h5A, 1, 1'b1, 1);  // even parity should be 0: error
    sendFrame(8'hC3, 1, 1'b0, 1);  // correct
    chk("R4 head data first", rxData, 8'h5A);
    chk("R4 head parityErr first", parityErr, 1);
    readPop();
    chk("R4 head data second", rxData, 8'hC3);
    chk("R4 head parityErr second", parityErr, 0);
    readPop();
    chk("R1 empty after two reads", rxComplete, 0);
    parityEnable = 1'b0;

    // R5 R10: zero stop bit, then recovery
    sendFrame(8'h81, 0, 0, 0);
    chk("R5 frameErr set", frameErr, 1);
    chk("R5 data with frame error", rxData, 8'h81);
    readPop();
    sendFrame(8'h3C, 0, 0, 1);
    chk("R10 recovery data", rxData, 8'h3C);
    chk("R5 frameErr clear", frameErr, 0);
    readPop();

    // R9: short low glitch
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (400) @(negedge clk);
    chk("R9 glitch ignored", rxComplete, 0);

    // R3: interrupt enable masking
    irqEnable = 1'b0;
    sendFrame(8'h11, 0, 0, 1);
    chk("R3 irq masked", irq, 0);
    irqEnable = 1'b1;
    @(negedge clk);
    chk("R3 irq asserted", irq, 1);
    readPop();
    chk("R3 irq drops when empty", irq, 0);

    // R6 R7: overrun
    sendFrame(8'hA1, 0, 0, 1);
    sendFrame(8'hA2, 0, 0, 1);
    chk("R6 no overrun at full", overrun, 0);
    sendFrame(8'hA3, 0, 0, 1);
    chk("R6 overrun set", overrun, 1);
    sendFrame(8'hA4, 0, 0, 1);
    chk("R6 head kept", rxData, 8'hA1);
    readPop();
    chk("R7 overrun cleared", overrun, 0);
    chk("R6 second entry kept", rxData, 8'hA2);
    readPop();
    chk("R6 lost frames not buffered", rxComplete, 0);

    // R2: disable flushes
    sendFrame(8'h77, 0, 0, 1);
    sendFrame(8'h78, 0, 0, 1);
    sendFrame(8'h79, 0, 0, 1);
    rxEnable = 1'b0;
    @(negedge clk);
    chk("R2 flush rxComplete", rxComplete, 0);
    chk("R2 flush overrun", overrun, 0);
    sendFrame(8'h12, 0, 0, 1);
    chk("R2 disabled ignores frames", rxComplete, 0);
    rxEnable = 1'b1;
    @(negedge clk);
    sendFrame(8'h34, 0, 0, 1);
    chk("R2 re-enabled data", rxData, 8'h34);
    readPop();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule